// File: doc/BRIEF.md
# Three-Digit Sequential Door Lock

This block compares three digits, entered one after another, with a stored three-digit code and releases a door only when all three match. A user first pulses the synchronous clear, then puts each digit on the entry bus and raises a one-cycle strobe. A controller produces a one-hot select that picks which stored digit is compared against the entry bus. An equality comparator sends the result back to the controller.

The state register is encoded so that its low bits are the select word and its top bit is the door-open output. No separate output decoding is needed. A wrong digit sends the lock to a dead state, and only the clear input brings it back. The stored digits are loaded through a small write port that the clear input does not affect.

Top module: `seq_door_lock`

## Requirements
- R1: When `clr` is high at a rising clock edge, the state becomes the first-digit state (encoding 4'b0001). This holds for any value of the other inputs, and `door_open` is 0 afterwards.
- R2: When `clr` and `strobe` are both low, the state does not change.
- R3: When `strobe` is high and the entry matches the selected stored digit, the state moves from first to second (4'b0010), from second to third (4'b0100), and from third to open (4'b1000).
- R4: When `strobe` is high and the entry differs from the selected stored digit, the state becomes the dead state (4'b0000).
- R5: The open and dead states are left only through `clr`. A strobe in either state has no effect.
- R6: `sel` is the low three state bits, one-hot in the digit states: 001 selects digit 0, 010 selects digit 1, 100 selects digit 2. It is 000 in the open and dead states.
- R7: `door_open` is the top state bit. It is 1 only in the open state.
- R8: When `wr_en` is high, `wr_data` is written into stored digit `wr_idx` (0, 1 or 2; index 3 is ignored). `clr` does not change the stored digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high lock clear |
| strobe | input | 1 | One-cycle pulse marking a new entry |
| entry | input | DIGIT_W | Entered digit |
| wr_en | input | 1 | Stored-digit write enable |
| wr_idx | input | 2 | Index of the stored digit to write |
| wr_data | input | DIGIT_W | Value to store |
| sel | output | NUM_DIGITS | One-hot select of the compared digit |
| door_open | output | 1 | Door released |

## Verification
The bench builds the block with its default parameters: three digits of four bits each. With 4-bit digits, the bench can load codes that differ from the entered digit in a single bit, and codes at the extreme values 0 and 15. This shows that the comparator checks every bit. Three digits are enough to step through every state of the controller. This includes a wrong digit at each position and strobes sent in the terminal states.

// File: rtl/seq_door_lock_pkg.sv
package seq_door_lock_pkg;
  localparam int NUM_DIGITS = 3;
  localparam int STATE_W    = NUM_DIGITS + 1;
  typedef logic [STATE_W-1:0] lock_state_t;
  localparam lock_state_t ST_FIRST = 4'b0001;
  localparam lock_state_t ST_DEAD  = 4'b0000;
  localparam lock_state_t ST_OPEN  = 4'b1000;
endpackage

// File: rtl/lock_code_store.sv
module lock_code_store #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [1:0]            wr_idx,
  input  logic [DIGIT_W-1:0]    wr_data,
  input  logic [NUM_DIGITS-1:0] sel,
  output logic [DIGIT_W-1:0]    picked
);
  logic [DIGIT_W-1:0] code_q [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    always_ff @(posedge clk)
      if (wr_en && (wr_idx == 2'(g))) code_q[g] <= wr_data;
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (sel[i]) picked = picked | code_q[i];
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter int NUM_DIGITS = 3,
  localparam int STATE_W = NUM_DIGITS + 1
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               strobe,
  input  logic               match,
  output logic [STATE_W-1:0] state
);
  import seq_door_lock_pkg::*;
  logic [STATE_W-1:0] nxt;

  always_comb begin
    nxt = state;
    if (strobe && state[NUM_DIGITS-1:0] != '0)
      nxt = match ? (state << 1) : '0;
  end

  always_ff @(posedge clk)
    if (clr) state <= STATE_W'(1);
    else     state <= nxt;
endmodule

// File: rtl/seq_door_lock.sv
module seq_door_lock #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  strobe,
  input  logic [DIGIT_W-1:0]    entry,
  input  logic                  wr_en,
  input  logic [1:0]            wr_idx,
  input  logic [DIGIT_W-1:0]    wr_data,
  output logic [NUM_DIGITS-1:0] sel,
  output logic                  door_open
);
  localparam int STATE_W = NUM_DIGITS + 1;
  logic [STATE_W-1:0] state;
  logic [DIGIT_W-1:0] picked;
  logic               match;

  lock_code_store #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sel(sel), .picked(picked));

  assign match = (picked == entry);

  lock_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk(clk), .clr(clr), .strobe(strobe), .match(match), .state(state));

  assign sel       = state[NUM_DIGITS-1:0];
  assign door_open = state[NUM_DIGITS];
endmodule

// File: rtl/seq_door_lock_chk.sv
module seq_door_lock_chk #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3
) (
  input logic                  clk,
  input logic                  clr,
  input logic                  strobe,
  input logic [NUM_DIGITS-1:0] sel,
  input logic                  door_open
);
  logic seen_clr = 1'b0;
  always_ff @(posedge clk) if (clr) seen_clr <= 1'b1;

  // R1
  clr_to_first_chk: assert property (@(posedge clk)
    clr |=> (sel == NUM_DIGITS'(1) && !door_open));
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    !strobe |=> ($stable(sel) && $stable(door_open)));
  // R5
  open_sticky_chk: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    door_open |=> door_open);
  // R5
  dead_sticky_chk: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    (sel == '0 && !door_open) |=> (sel == '0 && !door_open));
  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!seen_clr)
    $onehot0(sel));
  // R7
  open_no_sel_chk: assert property (@(posedge clk) disable iff (!seen_clr)
    door_open |-> sel == '0);
endmodule

bind seq_door_lock seq_door_lock_chk #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .clr(clr), .strobe(strobe), .sel(sel), .door_open(door_open));

// File: tb/test_seq_door_lock.sv
module test_seq_door_lock;
  logic       clk = 0;
  logic       clr = 0, strobe = 0, wr_en = 0;
  logic [3:0] entry = 0, wr_data = 0;
  logic [1:0] wr_idx = 0;
  logic [2:0] sel;
  logic       door_open;
  int checks = 0, failures = 0;

  seq_door_lock i_seq_door_lock (.clk, .clr, .strobe, .entry, .wr_en,
    .wr_idx, .wr_data, .sel, .door_open);

  always #10 clk = ~clk;

  task automatic expect_st(input string req, input logic [3:0] exp);
    checks++;
    if ({door_open, sel} !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, {door_open, sel}, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #5; endtask

  task automatic load(input logic [1:0] i, input logic [3:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic do_clr(); clr = 1; cyc(); clr = 0; endtask

  task automatic enter(input logic [3:0] d);
    entry = d; strobe = 1; cyc(); strobe = 0;
  endtask

  task automatic t_reset();
    clr = 1; strobe = 1; entry = 4'hF; cyc(); clr = 0; strobe = 0;
    expect_st("R1", 4'b0001);
  endtask

  task automatic t_unlock();
    load(0, 4'h3); load(1, 4'hA); load(2, 4'hF); do_clr();
    expect_st("R6", 4'b0001);
    entry = 4'h3; cyc(); cyc(); expect_st("R2", 4'b0001);
    enter(4'h3); expect_st("R3", 4'b0010);
    enter(4'hA); expect_st("R3", 4'b0100);
    cyc(); expect_st("R2", 4'b0100);
    enter(4'hF); expect_st("R7", 4'b1000);
    enter(4'h0); expect_st("R5", 4'b1000);
    cyc(); expect_st("R5", 4'b1000);
  endtask

  task automatic t_wrong(input int pos);
    do_clr();
    for (int k = 0; k < pos; k++) enter(k == 0 ? 4'h3 : 4'hA);
    enter(pos == 0 ? 4'h2 : pos == 1 ? 4'hB : 4'h7);
    expect_st("R4", 4'b0000);
    enter(pos == 0 ? 4'h3 : pos == 1 ? 4'hA : 4'hF);
    expect_st("R5", 4'b0000);
  endtask

  task automatic t_store();
    load(0, 4'h0); load(1, 4'h0); load(2, 4'h0);
    load(3, 4'h9);
    do_clr(); do_clr();
    enter(4'h0); enter(4'h0); enter(4'h0);
    expect_st("R8", 4'b1000);
    load(1, 4'h5); do_clr();
    enter(4'h0); enter(4'h5); expect_st("R8", 4'b0100);
  endtask

  initial begin
    #200000;
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_unlock();
    t_wrong(0); t_wrong(1); t_wrong(2);
    do_clr(); expect_st("R1", 4'b0001);
    t_store();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule